// File: doc/BRIEF.md
# Scaled Float-to-Integer Converter

This block turns an IEEE-754 single-precision value into a 32-bit integer. It first multiplies the value by a power of two, two raised to a 4-bit unsigned scale (0 to 15). It then rounds the scaled value to an integer and saturates it to the range of the result. A 3-bit selector picks the operation. The selector fixes both the rounding direction and whether the result is signed or unsigned, so no dynamic rounding setting takes part.

An upstream stage offers the float, the scale and the selector with `in_valid`. The block takes them on any cycle where `in_ready` is also high. One cycle later it presents the integer with `out_valid`, together with an invalid flag. The flag marks NaN inputs and results that had to be saturated.

The unsigned operation treats a negative non-NaN input with the signed rules. Such an input therefore gives zero or a negative two's-complement integer, and it is never clamped to zero.

Top module: `f2i_convert`

## Requirements
- R1: Selector code 0 rounds to the nearest integer with ties to even and gives a signed result.
- R2: Selector code 1 rounds toward zero, code 2 toward minus infinity and code 3 toward plus infinity, all signed; codes 4, 5 and 7 behave as code 1.
- R3: Selector code 6 rounds toward zero into an unsigned result; a negative non-NaN input is converted with the signed rules, giving zero or a negative result.
- R4: The value rounded is the input times 2 to the power of `in_scale`, read as unsigned 0 to 15.
- R5: A signed result above 0x7FFFFFFF saturates to 0x7FFFFFFF, and one below -2^31 saturates to 0x80000000, both with `out_invalid` set; exactly -2^31 is exact and leaves the flag clear.
- R6: An unsigned result above 0xFFFFFFFF saturates to 0xFFFFFFFF with `out_invalid` set.
- R7: A NaN of either sign gives 0x7FFFFFFF (0xFFFFFFFF for code 6) with `out_invalid` set; an infinity saturates by its sign with `out_invalid` set.
- R8: Zero and denormal inputs give 0 with `out_invalid` clear. The exceptions are a negative denormal under code 2, which gives 0xFFFFFFFF (-1), and a positive denormal under code 3, which gives 1.
- R9: `out_valid` rises exactly one cycle after each accepted handshake and at no other time. `in_ready` is low while reset is applied and high from the first cycle after it.
- R10: Synchronous active-low reset clears `out_valid`, `out_result` and `out_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can take an operand |
| in_float | input | 32 | Single-precision operand |
| in_scale | input | 4 | Power-of-two scale exponent |
| in_sel | input | 3 | Operation selector |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Integer result |
| out_invalid | output | 1 | NaN input or saturated result |

## Verification
Some properties are checked on every cycle. These are the one-cycle handshake latency, that a raised invalid flag always comes with one of the three saturation values, and that NaN inputs yield the positive limit. They also cover the return of zero for zero inputs, that signed operations never give a negative result for a positive input, and that the unsigned operation never clamps a negative input to a positive value.

Other behaviour can only be shown by the bench's scenarios, compared against an independent real-number model. This covers the exact rounding in every direction, including ties and the -1/+1 outcomes for denormals. It also covers the effect of the scale on the integer and the boundary just below each saturation limit.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
// Package f2i_pkg
// Shared constants, rounding-direction type and selector decode for the
// scaled float-to-integer converter. Assumes the 3-bit selector encoding
// listed in the brief; unused codes fold onto truncation.
package f2i_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_ZERO      = 2'd1,
        RND_DOWN      = 2'd2,
        RND_UP        = 2'd3
    } rnd_dir_e;

    typedef struct packed {
        rnd_dir_e dir;
        logic     unsigned_res;
    } conv_mode_t;

    localparam logic [SEL_W-1:0] SEL_NEAR   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TRUNC  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_FLOOR  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CEIL   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_UTRUNC = 3'd6;

    // Map a selector code onto rounding direction and result signedness.
    function automatic conv_mode_t decode_sel(input logic [SEL_W-1:0] sel);
        conv_mode_t m;
        m.unsigned_res = 1'b0;
        case (sel)
            SEL_NEAR:   m.dir = RND_NEAR_EVEN;
            SEL_FLOOR:  m.dir = RND_DOWN;
            SEL_CEIL:   m.dir = RND_UP;
            SEL_UTRUNC: begin
                m.dir          = RND_ZERO;
                m.unsigned_res = 1'b1;
            end
            default:    m.dir = RND_ZERO;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
// Module f2i_unpack
// Splits a binary floating-point word into sign, classification and
// significand, and computes the signed power-of-two shift that places the
// significand's least significant bit after the scale is applied.
// Assumes K_W is wide enough for exponent range plus scale range.
module f2i_unpack #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int SCALE_W = 4,
    parameter int K_W     = EXP_W + 3,
    localparam int FLT_W  = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic [FLT_W-1:0]      in_bits,
    input  logic [SCALE_W-1:0]    scale,
    output logic                  sign,
    output logic                  is_nan,
    output logic                  is_inf,
    output logic                  is_sub,
    output logic                  frac_nz,
    output logic [MANT_W-1:0]     mant,
    output logic signed [K_W-1:0] shift_k
);

    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int OFFSET = BIAS + FRAC_W;

    logic [EXP_W-1:0]      exp_f;
    logic [FRAC_W-1:0]     frac_f;
    logic signed [K_W-1:0] exp_s;
    logic signed [K_W-1:0] scl_s;

    // Field extraction and classification.
    always_comb begin
        sign    = in_bits[FLT_W-1];
        exp_f   = in_bits[FLT_W-2 -: EXP_W];
        frac_f  = in_bits[FRAC_W-1:0];
        frac_nz = |frac_f;
        is_nan  = (&exp_f) && frac_nz;
        is_inf  = (&exp_f) && !frac_nz;
        is_sub  = (exp_f == '0);
        mant    = {1'b1, frac_f};
    end

    // Weight of the significand LSB: biased exponent minus bias and fraction width, plus scale.
    always_comb begin
        exp_s   = signed'({{(K_W-EXP_W){1'b0}}, exp_f});
        scl_s   = signed'({{(K_W-SCALE_W){1'b0}}, scale});
        shift_k = exp_s + scl_s - K_W'(OFFSET);
    end

endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
// Module f2i_align
// Moves the significand to integer weight. A left shift gives an exact
// integer; a right shift also yields the first dropped bit (guard) and the
// OR of the rest (sticky). Denormals are far below one, so they reduce to a
// zero integer with sticky set when nonzero. Shifts beyond what the result
// width can hold raise too_big.
// Assumes MAG_W > MANT_W.
module f2i_align #(
    parameter int MANT_W = 24,
    parameter int MAG_W  = 33,
    parameter int K_W    = 11
) (
    input  logic [MANT_W-1:0]     mant,
    input  logic signed [K_W-1:0] shift_k,
    input  logic                  is_sub,
    input  logic                  frac_nz,
    output logic [MAG_W-1:0]      mag,
    output logic                  guard,
    output logic                  sticky,
    output logic                  too_big
);

    localparam int LSH_MAX = MAG_W - 1 - MANT_W;
    localparam int RSH_CAP = MANT_W + 2;
    localparam int WIDE_W  = MANT_W + RSH_CAP;
    localparam int SH_W    = $clog2(WIDE_W);

    logic signed [K_W-1:0] rsh_full;
    logic [SH_W-1:0]       sh_amt;
    logic [WIDE_W-1:0]     wide;

    // Select left or right alignment and derive guard/sticky for the right case.
    always_comb begin
        mag      = '0;
        guard    = 1'b0;
        sticky   = 1'b0;
        too_big  = 1'b0;
        sh_amt   = '0;
        wide     = '0;
        rsh_full = -shift_k;
        if (is_sub) begin
            sticky = frac_nz;
        end else if (shift_k >= 0) begin
            if (shift_k > K_W'(LSH_MAX)) begin
                too_big = 1'b1;
            end else begin
                sh_amt = shift_k[SH_W-1:0];
                mag    = {{(MAG_W-MANT_W){1'b0}}, mant} << sh_amt;
            end
        end else begin
            if (rsh_full > K_W'(RSH_CAP)) begin
                sh_amt = SH_W'(RSH_CAP);
            end else begin
                sh_amt = rsh_full[SH_W-1:0];
            end
            wide   = {mant, {RSH_CAP{1'b0}}} >> sh_amt;
            mag    = {{(MAG_W-MANT_W){1'b0}}, wide[WIDE_W-1 -: MANT_W]};
            guard  = wide[RSH_CAP-1];
            sticky = |wide[RSH_CAP-2:0];
        end
    end

    // Right alignment never produces integer bits above the significand width.
    always_comb begin
        if (!too_big && shift_k < 0) begin
            assert_align_width_R4: assert (mag[MAG_W-1:MANT_W] == '0)
                else $error("align produced bits above significand width");
        end
    end

endmodule

// File: rtl/f2i_round_sat.sv
`timescale 1ns/1ps
// Module f2i_round_sat
// Applies the rounding increment for the selected direction to the aligned
// magnitude, then saturates to the signed or unsigned range and raises the
// invalid flag for NaN, infinity and overflow. A negative non-NaN input
// under the unsigned operation takes the signed path.
// Assumes MAG_W == OUT_W + 1 and that the aligned magnitude plus one fits.
module f2i_round_sat
    import f2i_pkg::*;
#(
    parameter int OUT_W = 32,
    localparam int MAG_W = OUT_W + 1
) (
    input  conv_mode_t        mode,
    input  logic              sign,
    input  logic              is_nan,
    input  logic              is_inf,
    input  logic              too_big,
    input  logic [MAG_W-1:0]  mag,
    input  logic              guard,
    input  logic              sticky,
    output logic [OUT_W-1:0]  result,
    output logic              invalid
);

    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] U_MAX   = {OUT_W{1'b1}};

    logic             inc;
    logic [MAG_W-1:0] mag_r;
    logic             signed_path;
    logic             ovf;

    // Rounding increment chosen by direction.
    always_comb begin
        unique case (mode.dir)
            RND_NEAR_EVEN: inc = guard & (sticky | mag[0]);
            RND_ZERO:      inc = 1'b0;
            RND_DOWN:      inc = sign & (guard | sticky);
            RND_UP:        inc = !sign & (guard | sticky);
            default:       inc = 1'b0;
        endcase
        mag_r = mag + MAG_W'(inc);
    end

    // Range check and saturation to the signed or unsigned limits.
    always_comb begin
        signed_path = !mode.unsigned_res || (sign && !is_nan);
        ovf         = 1'b0;
        result      = '0;
        invalid     = 1'b0;
        if (is_nan) begin
            invalid = 1'b1;
            result  = mode.unsigned_res ? U_MAX : POS_MAX;
        end else if (signed_path) begin
            if (sign) begin
                ovf = is_inf || too_big || mag_r[MAG_W-1] ||
                      (mag_r[MAG_W-2] && (|mag_r[MAG_W-3:0]));
            end else begin
                ovf = is_inf || too_big || mag_r[MAG_W-1] || mag_r[MAG_W-2];
            end
            invalid = ovf;
            if (ovf) begin
                result = sign ? NEG_MIN : POS_MAX;
            end else begin
                result = sign ? (~mag_r[OUT_W-1:0] + 1'b1) : mag_r[OUT_W-1:0];
            end
        end else begin
            ovf     = is_inf || too_big || mag_r[MAG_W-1];
            invalid = ovf;
            result  = ovf ? U_MAX : mag_r[OUT_W-1:0];
        end
    end

    // A raised flag always comes with a saturation value.
    always_comb begin
        if (invalid) begin
            assert_sat_on_invalid_R5: assert (result == POS_MAX || result == NEG_MIN || result == U_MAX)
                else $error("invalid flag without saturation value");
        end
    end

endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
// Module f2i_convert (top)
// Scaled single-precision to 32-bit integer conversion with a valid/ready
// input and a registered result one cycle after each accepted operand.
// Assumes no backpressure on the result side; in_ready is high whenever
// the block is out of reset.
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int OUT_W   = 32,
    parameter int SCALE_W = 4,
    localparam int FLT_W  = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1,
    localparam int MAG_W  = OUT_W + 1,
    localparam int K_W    = EXP_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FLT_W-1:0]   in_float,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic [SEL_W-1:0]   in_sel,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_result,
    output logic               out_invalid
);

    logic                  sign, is_nan, is_inf, is_sub, frac_nz;
    logic [MANT_W-1:0]     mant;
    logic signed [K_W-1:0] shift_k;
    logic [MAG_W-1:0]      mag;
    logic                  guard, sticky, too_big;
    logic [OUT_W-1:0]      conv_result;
    logic                  conv_invalid;
    logic                  ready_q;
    logic                  accept;
    conv_mode_t            mode;

    assign mode     = decode_sel(in_sel);
    assign in_ready = ready_q;
    assign accept   = in_valid && ready_q;

    f2i_unpack #(
        .EXP_W   (EXP_W),
        .FRAC_W  (FRAC_W),
        .SCALE_W (SCALE_W),
        .K_W     (K_W)
    ) u_unpack (
        .in_bits (in_float),
        .scale   (in_scale),
        .sign    (sign),
        .is_nan  (is_nan),
        .is_inf  (is_inf),
        .is_sub  (is_sub),
        .frac_nz (frac_nz),
        .mant    (mant),
        .shift_k (shift_k)
    );

    f2i_align #(
        .MANT_W (MANT_W),
        .MAG_W  (MAG_W),
        .K_W    (K_W)
    ) u_align (
        .mant    (mant),
        .shift_k (shift_k),
        .is_sub  (is_sub),
        .frac_nz (frac_nz),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .too_big (too_big)
    );

    f2i_round_sat #(
        .OUT_W (OUT_W)
    ) u_round_sat (
        .mode    (mode),
        .sign    (sign),
        .is_nan  (is_nan),
        .is_inf  (is_inf),
        .too_big (too_big),
        .mag     (mag),
        .guard   (guard),
        .sticky  (sticky),
        .result  (conv_result),
        .invalid (conv_invalid)
    );

    // Input readiness: low in reset, high afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Result register: capture on accept, valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_result  <= conv_result;
                out_invalid <= conv_invalid;
            end
        end
    end

    // One-cycle latency from handshake to result.
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && in_ready));

    // NaN under a signed selector yields the positive limit with the flag.
    assert_nan_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (&in_float[FLT_W-2 -: EXP_W]) && (|in_float[FRAC_W-1:0])
         && in_sel != SEL_UTRUNC)
        |=> (out_result == {1'b0, {(OUT_W-1){1'b1}}} && out_invalid));

    // Signed or unsigned zero gives zero and no flag.
    assert_zero_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_float[FLT_W-2:0] == '0)
        |=> (out_result == '0 && !out_invalid));

    // Unsigned selector never clamps a negative non-NaN input to a positive value.
    assert_uneg_signed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sel == SEL_UTRUNC && in_float[FLT_W-1]
         && !((&in_float[FLT_W-2 -: EXP_W]) && (|in_float[FRAC_W-1:0])))
        |=> (out_result[OUT_W-1] || out_result == '0));

    // Signed selectors never produce a negative result for a positive input.
    assert_pos_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sel != SEL_UTRUNC && !in_float[FLT_W-1])
        |=> !out_result[OUT_W-1]);

endmodule

// File: tb/test_f2i_convert.sv
`timescale 1ns/1ps
// Bench for f2i_convert: directed and random operands, compared every clock
// against a real-number reference model.
module test_f2i_convert;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_float = '0;
    logic [3:0]  in_scale = '0;
    logic [2:0]  in_sel = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_tag = "";

    logic [31:0] exp_res[$];
    logic        exp_inv[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    f2i_convert i_f2i_convert (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_float    (in_float),
        .in_scale    (in_scale),
        .in_sel      (in_sel),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid)
    );

    // Reference: exact scaled value as a real, rounded and range-checked.
    function automatic void ref_conv(input logic [31:0] f, input logic [3:0] sc,
                                     input logic [2:0] sel,
                                     output logic [31:0] res, output logic inv);
        logic neg = f[31];
        int   e = int'(f[30:23]);
        int   fr = int'(f[22:0]);
        bit   uns = (sel == 3'd6);
        real  m, v, rv, fl, d;
        longint li;
        inv = 1'b0;
        if (e == 255) begin
            inv = 1'b1;
            if (fr != 0 || !neg) res = uns ? 32'hFFFFFFFF : 32'h7FFFFFFF;
            else                 res = 32'h80000000;
            return;
        end
        if (e == 0) m = real'(fr) * (2.0 ** real'(-149 + int'(sc)));
        else        m = real'(fr + (1 << 23)) * (2.0 ** real'(e - 150 + int'(sc)));
        v = neg ? -m : m;
        case (sel)
            3'd0: begin
                fl = $floor(v);
                d  = v - fl;
                if (d > 0.5)      rv = fl + 1.0;
                else if (d < 0.5) rv = fl;
                else              rv = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            3'd2:    rv = $floor(v);
            3'd3:    rv = $ceil(v);
            default: rv = (v >= 0.0) ? $floor(v) : $ceil(v);
        endcase
        if (uns && !neg) begin
            if (rv > 4294967295.0) begin
                res = 32'hFFFFFFFF; inv = 1'b1;
            end else begin
                li = longint'(rv); res = li[31:0];
            end
        end else if (rv > 2147483647.0) begin
            res = 32'h7FFFFFFF; inv = 1'b1;
        end else if (rv < -2147483648.0) begin
            res = 32'h80000000; inv = 1'b1;
        end else begin
            li = longint'(rv); res = li[31:0];
        end
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Record the expected result of every accepted operand.
    always @(posedge clk) begin
        logic [31:0] r;
        logic        iv;
        if (rst_n && in_valid && in_ready) begin
            ref_conv(in_float, in_scale, in_sel, r, iv);
            exp_res.push_back(r);
            exp_inv.push_back(iv);
            exp_tag.push_back(cur_tag);
        end
    end

    // Compare outputs against the model on every falling edge (R9 for presence).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                checks++;
                if (exp_res.size() == 0) begin
                    failures++;
                    $display("FAIL R9: out_valid=1 expected 0");
                end else begin
                    logic [31:0] r;
                    logic        iv;
                    string       t;
                    r  = exp_res.pop_front();
                    iv = exp_inv.pop_front();
                    t  = exp_tag.pop_front();
                    if (out_result !== r || out_invalid !== iv) begin
                        failures++;
                        $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                                 t, out_result, out_invalid, r, iv);
                    end
                end
            end else if (exp_res.size() != 0) begin
                checks++;
                failures++;
                $display("FAIL R9: out_valid=0 expected 1");
                void'(exp_res.pop_front());
                void'(exp_inv.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    task automatic send(input logic [31:0] f, input logic [3:0] sc,
                        input logic [2:0] sel, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_float = f;
        in_scale = sc;
        in_sel   = sel;
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10 / R9: reset state and readiness.
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_invalid !== 1'b0) begin
            failures++;
            $display("FAIL R10: valid=%b result=%h invalid=%b expected 0 0 0",
                     out_valid, out_result, out_invalid);
        end
        checks++;
        if (in_ready !== 1'b0) begin
            failures++;
            $display("FAIL R9: in_ready=%b in reset expected 0", in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1) begin
            failures++;
            $display("FAIL R9: in_ready=%b after reset expected 1", in_ready);
        end

        // R1: nearest-even, including ties.
        send(32'h40200000, 4'd0, 3'd0, "R1");
        send(32'h40600000, 4'd0, 3'd0, "R1");
        send(32'hC0200000, 4'd0, 3'd0, "R1");
        send(32'h40300000, 4'd0, 3'd0, "R1");
        send(32'h3F000000, 4'd0, 3'd0, "R1");
        idle(2);
        // R2: directed directions and folded codes.
        for (int s = 1; s < 8; s++) begin
            if (s != 6) begin
                send(32'h40300000, 4'd0, 3'(s), "R2");
                send(32'hC0300000, 4'd0, 3'(s), "R2");
            end
        end
        idle(1);
        // R3: unsigned truncate, negative inputs signed.
        send(32'hC0B00000, 4'd0, 3'd6, "R3");
        send(32'hBF400000, 4'd0, 3'd6, "R3");
        send(32'h4F32D05E, 4'd0, 3'd6, "R3");
        send(32'hCF000000, 4'd0, 3'd6, "R3");
        // R4: scaling.
        send(32'h3F800000, 4'd15, 3'd1, "R4");
        send(32'h3FC00000, 4'd1, 3'd0, "R4");
        send(32'h3F400000, 4'd2, 3'd1, "R4");
        send(32'h3E800000, 4'd1, 3'd0, "R4");
        idle(1);
        // R5: signed saturation edges.
        send(32'h4F000000, 4'd0, 3'd1, "R5");
        send(32'hCF000000, 4'd0, 3'd1, "R5");
        send(32'h4EFFFFFF, 4'd0, 3'd3, "R5");
        send(32'h47800000, 4'd15, 3'd1, "R5");
        send(32'hC7800000, 4'd15, 3'd2, "R5");
        send(32'hCF000001, 4'd0, 3'd1, "R5");
        // R6: unsigned saturation edges.
        send(32'h4F800000, 4'd0, 3'd6, "R6");
        send(32'h4F7FFFFF, 4'd0, 3'd6, "R6");
        send(32'h47800000, 4'd15, 3'd6, "R6");
        // R7: NaN and infinity.
        send(32'h7FC00000, 4'd0, 3'd0, "R7");
        send(32'h7FC00000, 4'd0, 3'd6, "R7");
        send(32'hFFC00001, 4'd3, 3'd2, "R7");
        send(32'h7F800000, 4'd0, 3'd1, "R7");
        send(32'hFF800000, 4'd0, 3'd3, "R7");
        send(32'hFF800000, 4'd0, 3'd6, "R7");
        idle(1);
        // R8: zeros and denormals.
        send(32'h00000000, 4'd0, 3'd3, "R8");
        send(32'h80000000, 4'd0, 3'd2, "R8");
        send(32'h00000001, 4'd15, 3'd3, "R8");
        send(32'h00000001, 4'd0, 3'd2, "R8");
        send(32'h80000001, 4'd0, 3'd2, "R8");
        send(32'h80000001, 4'd0, 3'd3, "R8");
        send(32'h007FFFFF, 4'd15, 3'd0, "R8");
        idle(2);

        // Random operands near the integer range, with gaps (R4 scaling across modes).
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] f;
            logic [7:0]  e;
            if ($urandom_range(9, 0) == 0) e = 8'($urandom);
            else                           e = 8'($urandom_range(165, 110));
            f = {1'($urandom), e, 23'($urandom)};
            send(f, 4'($urandom), 3'($urandom), "R4");
            if ($urandom_range(7, 0) == 0) idle(1);
        end
        idle(3);
        finish_run();
    end

endmodule